// File: doc/BRIEF.md
# PHY Test-Port Transaction Sequencer

This block turns single-byte register requests from a host into the slow, bit-by-bit signalling that a PHY's test port expects. The port has a strobe clock, a clear line, an enable line, an 8-bit value bus into the PHY and an 8-bit monitor bus out of it. A transaction first releases the clear line. A code phase then presents the register address, framed by strobe-clock edges and qualified by the enable. A data phase follows and presents the value to store, closed by a rising strobe clock.

Each single change on the port is held for `SETTLE_CYC` system clocks before the next change is made, so the PHY sees clean, slow edges. A read runs the same code phase, samples the monitor bus, and then writes the sampled byte back in the data phase so that the register keeps its contents. Addresses above `MAX_ADDR` (0x97 by default) are refused with an error response and leave the port untouched. The host side is a valid/ready request with a one-cycle response pulse.

Top module: `phy_testport_ctrl`

## Requirements
- R1: After reset, req_ready=1, rsp_valid=0, tp_clear=1, tp_strobe=0, tp_enable=0 and tp_wr_byte=0x00.
- R2: A request with req_addr <= MAX_ADDR is taken at the rising edge where req_valid and req_ready are both 1. At that same edge tp_clear goes to 0. req_ready stays 0 from then until the response cycle has ended.
- R3: The code phase changes the port in this order, taking the accept edge as E0 and S = SETTLE_CYC: tp_strobe=1 at E0+S, tp_wr_byte=address at E0+2S, tp_enable=1 at E0+3S, tp_strobe=0 at E0+4S, and tp_enable=0 at E0+5S.
- R4: The data phase drives tp_strobe=0 at E0+6S, puts the data byte on tp_wr_byte at E0+7S, and drives tp_strobe=1 at E0+8S.
- R5: Each port change holds for at least S cycles before the next change. A single edge never changes more than one port signal. tp_enable rises only while tp_strobe is 1, and tp_strobe falls only while tp_enable is 1.
- R6: rsp_valid is 1 for exactly the one cycle after edge E0+9S. For a write in that cycle, rsp_err=0 and rsp_rdata=0x00. req_ready returns to 1 in the following cycle.
- R7: For a read (req_write=0), tp_rd_byte is sampled at edge E0+6S. The sampled byte appears on rsp_rdata with rsp_err=0, and it is the byte driven onto tp_wr_byte at E0+7S. A change of tp_rd_byte after E0+6S has no effect on either.
- R8: A request with req_addr > MAX_ADDR is answered by rsp_valid=1, rsp_err=1 and rsp_rdata=0x00 in the cycle after the accept edge. No port signal changes. req_ready returns to 1 one cycle later.
- R9: req_addr equal to MAX_ADDR (0x97) is legal and runs the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 8 | Target register address |
| req_wdata | input | 8 | Byte to write (ignored on reads) |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Address out of range |
| rsp_rdata | output | 8 | Byte sampled on a read, 0 otherwise |
| tp_strobe | output | 1 | Test-port strobe clock |
| tp_clear | output | 1 | Test-port clear |
| tp_enable | output | 1 | Test-port enable, marks the code phase |
| tp_wr_byte | output | 8 | Value bus into the PHY |
| tp_rd_byte | input | 8 | Monitor bus from the PHY |

## Verification
Every result has a fixed due time in multiples of S after the accept edge E0. Port step n lands at E0+n·S, the read sample is taken at E0+6S, the response appears after E0+9S, and an error response appears after E0+1. The bench runs with a small S. It counts k cycles from the accept edge and samples every output at the falling edge after E0+k. The expected level of each port signal comes from the step index k/S, so each cycle of each transaction is checked, not only its end state. For reads, the monitor byte is changed right after the sample edge, which shows that the sample was taken at the stated edge.

// File: rtl/phy_tp_pkg.sv
package phy_tp_pkg;
  localparam int unsigned TP_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLR,
    ST_C_CLKHI,
    ST_C_ADDR,
    ST_C_ENHI,
    ST_C_CLKLO,
    ST_C_ENLO,
    ST_D_CLKLO,
    ST_D_DATA,
    ST_D_CLKHI,
    ST_RESP
  } step_e;

  typedef struct packed {
    logic            strobe;
    logic            clear;
    logic            enable;
    logic [TP_W-1:0] value;
  } port_t;

  function automatic step_e step_after(input step_e s);
    case (s)
      ST_CLR:     return ST_C_CLKHI;
      ST_C_CLKHI: return ST_C_ADDR;
      ST_C_ADDR:  return ST_C_ENHI;
      ST_C_ENHI:  return ST_C_CLKLO;
      ST_C_CLKLO: return ST_C_ENLO;
      ST_C_ENLO:  return ST_D_CLKLO;
      ST_D_CLKLO: return ST_D_DATA;
      ST_D_DATA:  return ST_D_CLKHI;
      ST_D_CLKHI: return ST_RESP;
      default:    return ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/phy_tp_timer.sv
module phy_tp_timer #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = restart || run;
    if (restart)                  cnt_d = '0;
    else if (run && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    else                          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LAST);

  // R5
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/phy_tp_port.sv
module phy_tp_port
  import phy_tp_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter,
  input  step_e           nxt_step,
  input  logic [TP_W-1:0] addr,
  input  logic [TP_W-1:0] data,
  output port_t           port_q
);
  localparam int unsigned GW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [GW-1:0] GMAX = GW'(SETTLE_CYC - 1);

  port_t port_d;

  always_comb begin
    port_d = port_q;
    if (enter) begin
      case (nxt_step)
        ST_CLR:     port_d.clear  = 1'b0;
        ST_C_CLKHI: port_d.strobe = 1'b1;
        ST_C_ADDR:  port_d.value  = addr;
        ST_C_ENHI:  port_d.enable = 1'b1;
        ST_C_CLKLO: port_d.strobe = 1'b0;
        ST_C_ENLO:  port_d.enable = 1'b0;
        ST_D_CLKLO: port_d.strobe = 1'b0;
        ST_D_DATA:  port_d.value  = data;
        ST_D_CLKHI: port_d.strobe = 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q.strobe <= 1'b0;
      port_q.clear  <= 1'b1;
      port_q.enable <= 1'b0;
      port_q.value  <= '0;
    end else if (enter) begin
      port_q <= port_d;
    end
  end

  // Spacing checker: cycles since the last port change, saturating.
  logic          changed;
  logic [GW-1:0] gap_q;
  assign changed = (port_d != port_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gap_q <= GMAX;
    else if (changed)       gap_q <= '0;
    else if (gap_q != GMAX) gap_q <= gap_q + 1'b1;
  end

  // R5
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    changed |-> gap_q == GMAX);
  // R5
  one_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({port_d.strobe != port_q.strobe, port_d.clear != port_q.clear,
                port_d.enable != port_q.enable, port_d.value != port_q.value}) <= 1);
  // R5
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_q.enable) |-> port_q.strobe);
  // R5
  strobe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_q.strobe) |-> port_q.enable);
  // R3
  strobe_rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_q.strobe) |-> $stable(port_q.value));
endmodule

// File: rtl/phy_tp_seq.sv
module phy_tp_seq
  import phy_tp_pkg::*;
#(
  parameter logic [TP_W-1:0] MAX_ADDR = 8'h97
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [TP_W-1:0] req_addr,
  input  logic [TP_W-1:0] req_wdata,
  input  logic            req_write,
  input  logic [TP_W-1:0] rd_byte,
  input  logic            tmr_done,
  output logic            req_ready,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [TP_W-1:0] rsp_rdata,
  output logic            enter,
  output step_e           nxt_step,
  output logic            tmr_run,
  output logic [TP_W-1:0] step_addr,
  output logic [TP_W-1:0] step_data
);
  step_e           state_q;
  logic            accept, legal, capture;
  logic [TP_W-1:0] addr_q, wdata_q, rdata_q;
  logic            wr_q, err_q;

  assign legal   = (req_addr <= MAX_ADDR);
  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign capture = (state_q == ST_C_ENLO) && tmr_done && !wr_q;

  always_comb begin
    nxt_step = state_q;
    case (state_q)
      ST_IDLE: if (req_valid) nxt_step = legal ? ST_CLR : ST_RESP;
      ST_RESP: nxt_step = ST_IDLE;
      default: if (tmr_done) nxt_step = step_after(state_q);
    endcase
    enter = (nxt_step != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= ST_IDLE;
    else if (enter) state_q <= nxt_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
      err_q   <= !legal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (accept)  rdata_q <= '0;
    else if (capture) rdata_q <= rd_byte;
  end

  assign tmr_run   = (state_q != ST_IDLE) && (state_q != ST_RESP);
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
  assign step_addr = addr_q;
  assign step_data = wr_q ? wdata_q : rdata_q;

  // R2
  legal_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && legal) |=> (!req_ready && !rsp_valid));
  // R8
  illegal_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !legal) |=> (rsp_valid && rsp_err && rsp_rdata == '0));
  // R6
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
endmodule

// File: rtl/phy_testport_ctrl.sv
module phy_testport_ctrl
  import phy_tp_pkg::*;
#(
  parameter int unsigned     SETTLE_CYC = 4,
  parameter logic [TP_W-1:0] MAX_ADDR   = 8'h97
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [TP_W-1:0] req_addr,
  input  logic [TP_W-1:0] req_wdata,
  input  logic            req_write,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [TP_W-1:0] rsp_rdata,
  output logic            tp_strobe,
  output logic            tp_clear,
  output logic            tp_enable,
  output logic [TP_W-1:0] tp_wr_byte,
  input  logic [TP_W-1:0] tp_rd_byte
);
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic            enter, tmr_run, tmr_done;
  step_e           nxt_step;
  logic [TP_W-1:0] step_addr, step_data;
  port_t           port_q;

  phy_tp_seq #(.MAX_ADDR(MAX_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .rd_byte(tp_rd_byte), .tmr_done(tmr_done),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .enter(enter), .nxt_step(nxt_step),
    .tmr_run(tmr_run), .step_addr(step_addr), .step_data(step_data)
  );

  phy_tp_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .restart(enter), .run(tmr_run), .done(tmr_done)
  );

  phy_tp_port #(.SETTLE_CYC(SETTLE_CYC)) u_port (
    .clk(clk), .rst_n(rst_int_n), .enter(enter), .nxt_step(nxt_step),
    .addr(step_addr), .data(step_data), .port_q(port_q)
  );

  assign tp_strobe  = port_q.strobe;
  assign tp_clear   = port_q.clear;
  assign tp_enable  = port_q.enable;
  assign tp_wr_byte = port_q.value;

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && rsp_err) |-> ($stable(tp_strobe) && $stable(tp_clear) &&
                                $stable(tp_enable) && $stable(tp_wr_byte)));
  // R2
  clear_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!req_ready && !rsp_valid) |-> !tp_clear);
endmodule

// File: tb/tb_phy_testport_ctrl.sv
module tb_phy_testport_ctrl;
  localparam int unsigned S = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_wdata = 8'h00;
  logic       req_write = 1'b0;
  logic       rsp_valid, rsp_err;
  logic [7:0] rsp_rdata;
  logic       tp_strobe, tp_clear, tp_enable;
  logic [7:0] tp_wr_byte;
  logic [7:0] tp_rd_byte = 8'h00;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic       prev_strobe = 1'b0;
  logic [7:0] prev_byte = 8'h00;
  logic       prev_clear = 1'b1;

  always #5 clk = ~clk;

  phy_testport_ctrl #(.SETTLE_CYC(S), .MAX_ADDR(8'h97)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .tp_strobe(tp_strobe), .tp_clear(tp_clear), .tp_enable(tp_enable),
    .tp_wr_byte(tp_wr_byte), .tp_rd_byte(tp_rd_byte)
  );

  task automatic chk(input string tag, input int k, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s k=%0d actual=%0h expected=%0h", tag, k, act, exp);
    end
  endtask

  task automatic run_txn(input logic [7:0] a, input logic [7:0] wd, input bit wr, input logic [7:0] rd);
    bit         legal = (a <= 8'h97);
    logic [7:0] dbyte = wr ? wd : rd;
    @(negedge clk);
    tp_rd_byte = rd;
    req_addr = a; req_wdata = wd; req_write = wr; req_valid = 1'b1;
    chk("R2 ready before accept", -1, req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!legal) begin
      // R8: error pulse at k=0, port untouched
      chk("R8 rsp_valid", 0, rsp_valid, 1);
      chk("R8 rsp_err", 0, rsp_err, 1);
      chk("R8 rsp_rdata", 0, rsp_rdata, 0);
      chk("R8 ready low", 0, req_ready, 0);
      chk("R8 port", 0, {tp_strobe, tp_clear, tp_enable, tp_wr_byte},
          {prev_strobe, prev_clear, 1'b0, prev_byte});
      @(negedge clk);
      chk("R8 ready back", 1, req_ready, 1);
      chk("R8 rsp gone", 1, rsp_valid, 0);
      chk("R8 port after", 1, {tp_strobe, tp_clear, tp_enable, tp_wr_byte},
          {prev_strobe, prev_clear, 1'b0, prev_byte});
    end else begin
      for (int k = 0; k <= 9 * S + 1; k++) begin
        int         s = k / S;
        logic       e_stb, e_en;
        logic [7:0] e_val;
        if (k > 0) @(negedge clk);
        e_stb = (s == 0) ? prev_strobe : ((s >= 1 && s <= 3) || s >= 8);
        e_en  = (s == 3 || s == 4);
        e_val = (s < 2) ? prev_byte : ((s <= 6) ? a : dbyte);
        if (k <= 9 * S) begin
          chk("R2 clear low", k, tp_clear, 0);
          chk("R3 R4 strobe", k, tp_strobe, e_stb);
          chk("R3 enable", k, tp_enable, e_en);
          chk("R3 R4 R7 wr_byte", k, tp_wr_byte, e_val);
        end
        if (k < 9 * S) begin
          chk("R2 ready busy", k, req_ready, 0);
          chk("R6 no early rsp", k, rsp_valid, 0);
        end else if (k == 9 * S) begin
          chk("R6 rsp_valid", k, rsp_valid, 1);
          chk("R6 ready low in rsp", k, req_ready, 0);
          chk("R6 rsp_err", k, rsp_err, 0);
          chk(wr ? "R6 rdata zero" : "R7 rdata", k, rsp_rdata, wr ? 8'h00 : rd);
        end else begin
          chk("R6 ready back", k, req_ready, 1);
          chk("R6 one-cycle rsp", k, rsp_valid, 0);
        end
        // R7: disturb monitor bus right after the sample edge
        if (k == 6 * S) tp_rd_byte = ~rd;
      end
      prev_strobe = 1'b1;
      prev_byte = dbyte;
      prev_clear = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 ready", 0, req_ready, 1);
    chk("R1 rsp_valid", 0, rsp_valid, 0);
    chk("R1 clear", 0, tp_clear, 1);
    chk("R1 strobe", 0, tp_strobe, 0);
    chk("R1 enable", 0, tp_enable, 0);
    chk("R1 wr_byte", 0, tp_wr_byte, 0);

    run_txn(8'h98, 8'h11, 1'b1, 8'h00);   // R8 before any legal traffic
    run_txn(8'h17, 8'h5A, 1'b1, 8'hC3);
    run_txn(8'h44, 8'h00, 1'b0, 8'hA5);   // R7
    run_txn(8'h97, 8'hFF, 1'b1, 8'h00);   // R9
    run_txn(8'h97, 8'h00, 1'b0, 8'h3C);   // R9 read
    run_txn(8'hFF, 8'h22, 1'b0, 8'h77);   // R8
    run_txn(8'h00, 8'h81, 1'b1, 8'h18);
    run_txn(8'hA0, 8'h01, 1'b1, 8'h00);   // R8
    for (int i = 0; i < 8; i++) begin
      run_txn(8'(i * 19), 8'(i * 37 + 5), i[0], 8'(8'hF0 ^ (i * 13)));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule